// File: doc/BRIEF.md
# Multi-Output Pattern Memory Tone Sequencer

This block produces many square-wave tones at once by replaying stored bit patterns instead of running a separate divider for each tone. Each stored word holds the next level of every tone in a group, one bit per tone. A modulo address counter walks through the words, one word per enabled master clock tick. It wraps at the least common multiple of the division ratios held in that group, so every tone repeats with an exact period.

The tones are split into two groups. Each group has its own pattern memory and its own address counter. Putting into one group the ratios that share factors keeps that group's least common multiple, and so its memory depth, small. The memory contents are computed during elaboration from the ratio lists. Bit k of word a is high when (a mod Nk) is less than floor(Nk/2).

The memory read goes through an output register, so every tone output is a flop output. All tones move on one clock edge. A single enable gates both counters and both output registers.

Top module: `tone_seq_top`

## Requirements
- R1: While rstN is low, and at the first sampling point after it, every bit of toneA and toneB is 0, and both address counters sit at word 0.
- R2: A tone with ratio N is high for the first floor(N/2) of every N enabled clocks and low for the rest, so its period is exactly N. Odd ratios therefore have a shorter high than low phase (ratio 3: 1 high, 2 low).
- R3: The read is registered. The first enabled edge after reset loads word 0, in which every used tone bit is 1 (toneA = 0x1FFF, toneB = 0x0007 with default parameters). After the m-th enabled edge the outputs show word (m-1) mod depth.
- R4: Each group's counter wraps at the least common multiple of that group's ratios: 120 words for group A and 105 words for group B with the defaults. The output sequence repeats exactly after that many enabled clocks.
- R5: Spare word bits that carry no tone are always 0: toneA bits 15 to 13 and toneB bits 15 to 3 with the defaults.
- R6: While enable is low, neither counter advances and both tone words hold their values.
- R7: Both groups step on the same edge and restart together on reset, so under any enable pattern both groups follow one shared count of enabled edges.
- R8: Default bit map: toneA bit k uses ratio k-th of (2,3,4,5,6,8,10,12,15,20,24,30,40); toneB bits 0, 1 and 2 use ratios 3, 5 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; one pattern word per enabled rising edge |
| rstN | input | 1 | Active-low synchronous reset of counters and output registers |
| enable | input | 1 | Advances both counters and loads both output registers when high |
| toneA | output | WORD_W (16) | Registered tone levels of group A; spare bits are 0 |
| toneB | output | WORD_W (16) | Registered tone levels of group B; spare bits are 0 |

## Verification
The bench runs an unbroken enabled stream over two full periods of each group. It compares the second period word for word against the first, which shows whether each counter wraps at exactly the right count. It also counts high cycles per tone over one full group period, which separates correct odd-ratio duty from rounding errors. Stretches with enable low, including an alternating enable pattern, show whether the counters and outputs truly hold and whether both groups stay on a shared count. A reset applied in the middle of a run shows that both groups restart together with word 0 on the first enabled edge.

// File: rtl/tone_seq_pkg.sv
package tone_seq_pkg;

  localparam int unsigned MAX_TONES = 16;

  typedef int unsigned ratio_list_t [MAX_TONES];

  // strobes from the counter control to the pattern datapath
  typedef struct packed {
    logic rdEn;       // load the output register this edge
    logic firstWord;  // the word being loaded is word 0
  } seq_strobe_t;

  function automatic int unsigned gcdOf(input int unsigned a, input int unsigned b);
    int unsigned x;
    int unsigned y;
    int unsigned t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  // least common multiple of the first n ratios of a list
  function automatic int unsigned lcmOf(input ratio_list_t r, input int unsigned n);
    int unsigned acc;
    acc = 1;
    for (int i = 0; i < MAX_TONES; i++) begin
      if (i < int'(n)) acc = (acc / gcdOf(acc, r[i])) * r[i];
    end
    return acc;
  endfunction

  // pattern word for address a: bit k high during the first half of its ratio
  function automatic logic [MAX_TONES-1:0] toneWord(input ratio_list_t r,
                                                    input int unsigned n,
                                                    input int unsigned a);
    logic [MAX_TONES-1:0] w;
    w = '0;
    for (int k = 0; k < MAX_TONES; k++) begin
      if (k < int'(n)) w[k] = ((a % r[k]) < (r[k] / 2));
    end
    return w;
  endfunction

endpackage

// File: rtl/tone_seq_ctrl.sv
module tone_seq_ctrl
  import tone_seq_pkg::*;
#(
  parameter int unsigned DEPTH = 120,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  output logic [AW-1:0] addr,
  output seq_strobe_t   strobe
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic atLast;
  assign atLast = (addr == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr <= '0;
    end else if (enable) begin
      addr <= atLast ? '0 : addr + 1'b1;
    end
  end

  always_comb begin
    strobe.rdEn      = enable;
    strobe.firstWord = enable && (addr == '0);
  end

  // counter never leaves the group period
  assert_addr_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    addr <= LAST);

  // wrap back to word 0 after the last word of the period
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && atLast) |=> (addr == '0));

  // disabled counter holds
  assert_hold_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(addr));

  // reset parks the counter at word 0
  assert_reset_addr_R1: assert property (@(posedge clk)
    !rstN |=> (addr == '0));

endmodule

// File: rtl/tone_seq_path.sv
module tone_seq_path
  import tone_seq_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NUM_TONES = 13,
  parameter ratio_list_t RATIOS    = '{default: 1},
  parameter int unsigned DEPTH     = 120,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     addr,
  input  seq_strobe_t       strobe,
  output logic [WORD_W-1:0] toneOut
);

  logic [WORD_W-1:0] patRom [DEPTH];

  // pattern contents computed at elaboration from the ratio list
  initial begin
    logic [MAX_TONES-1:0] full;
    for (int a = 0; a < int'(DEPTH); a++) begin
      full = toneWord(RATIOS, NUM_TONES, a);
      patRom[a] = full[WORD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toneOut <= '0;
    end else if (strobe.rdEn) begin
      toneOut <= patRom[addr];
    end
  end

  // word 0 drives every used tone high
  assert_first_word_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.firstWord |=> (toneOut[NUM_TONES-1:0] == '1));

  // output register holds while not strobed
  assert_hold_out_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(toneOut));

  assert_reset_out_R1: assert property (@(posedge clk)
    !rstN |=> (toneOut == '0));

  generate
    if (NUM_TONES < WORD_W) begin : g_spare
      assert_spare_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
        toneOut[WORD_W-1:NUM_TONES] == '0);
    end
  endgenerate

endmodule

// File: rtl/tone_seq_top.sv
module tone_seq_top
  import tone_seq_pkg::*;
#(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned NUM_A   = 13,
  parameter ratio_list_t RATIO_A = '{2, 3, 4, 5, 6, 8, 10, 12, 15, 20, 24, 30, 40, 1, 1, 1},
  parameter int unsigned NUM_B   = 3,
  parameter ratio_list_t RATIO_B = '{3, 5, 7, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  output logic [WORD_W-1:0] toneA,
  output logic [WORD_W-1:0] toneB
);

  localparam int unsigned DEPTH_A = lcmOf(RATIO_A, NUM_A);
  localparam int unsigned DEPTH_B = lcmOf(RATIO_B, NUM_B);
  localparam int unsigned AW_A = (DEPTH_A > 1) ? $clog2(DEPTH_A) : 1;
  localparam int unsigned AW_B = (DEPTH_B > 1) ? $clog2(DEPTH_B) : 1;

  logic [AW_A-1:0] addrA;
  logic [AW_B-1:0] addrB;
  seq_strobe_t     strobeA;
  seq_strobe_t     strobeB;

  tone_seq_ctrl #(.DEPTH(DEPTH_A)) u_ctrlA (
    .clk(clk), .rstN(rstN), .enable(enable), .addr(addrA), .strobe(strobeA));

  tone_seq_path #(.WORD_W(WORD_W), .NUM_TONES(NUM_A), .RATIOS(RATIO_A), .DEPTH(DEPTH_A)) u_pathA (
    .clk(clk), .rstN(rstN), .addr(addrA), .strobe(strobeA), .toneOut(toneA));

  tone_seq_ctrl #(.DEPTH(DEPTH_B)) u_ctrlB (
    .clk(clk), .rstN(rstN), .enable(enable), .addr(addrB), .strobe(strobeB));

  tone_seq_path #(.WORD_W(WORD_W), .NUM_TONES(NUM_B), .RATIOS(RATIO_B), .DEPTH(DEPTH_B)) u_pathB (
    .clk(clk), .rstN(rstN), .addr(addrB), .strobe(strobeB), .toneOut(toneB));

  // both groups load on the same edge
  assert_lockstep_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobeA.rdEn == strobeB.rdEn);

endmodule

// File: tb/tone_seq_top_tb.sv
module tone_seq_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] toneA;
  logic [15:0] toneB;

  int errors = 0;
  int checks = 0;
  int k = 0;           // enabled edges since reset
  bit done = 1'b0;

  int unsigned ratA [13] = '{2, 3, 4, 5, 6, 8, 10, 12, 15, 20, 24, 30, 40};
  int unsigned ratB [3]  = '{3, 5, 7};

  always #5 clk = ~clk;

  tone_seq_top u_dut (.clk(clk), .rstN(rstN), .enable(enable), .toneA(toneA), .toneB(toneB));

  function automatic logic [15:0] expA(input int m);
    logic [15:0] w = '0;
    if (m > 0) for (int i = 0; i < 13; i++) w[i] = (((m - 1) % ratA[i]) < (ratA[i] / 2));
    return w;
  endfunction

  function automatic logic [15:0] expB(input int m);
    logic [15:0] w = '0;
    if (m > 0) for (int i = 0; i < 3; i++) w[i] = (((m - 1) % ratB[i]) < (ratB[i] / 2));
    return w;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (k=%0d)", tag, act, exp, k);
    end
  endtask

  task automatic tick(input logic en);
    enable = en;
    @(posedge clk);
    if (en) k++;
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    enable = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 toneA in reset", toneA, 16'h0000);
    chk("R1 toneB in reset", toneB, 16'h0000);
    rstN = 1'b1;
    k = 0;
  endtask

  task automatic testFirstWord();
    tick(1'b1);
    chk("R3 first word A", toneA, 16'h1FFF);
    chk("R3 first word B", toneB, 16'h0007);
    tick(1'b1);
    chk("R3 second word A", toneA, expA(k));
  endtask

  task automatic testWrap();
    logic [15:0] histA [120];
    logic [15:0] histB [105];
    doReset();
    for (int c = 0; c < 240; c++) begin
      tick(1'b1);
      chk("R2 R8 group A model", toneA, expA(k));
      chk("R2 R8 group B model", toneB, expB(k));
      chk("R5 spare A", toneA & 16'hE000, 16'h0000);
      chk("R5 spare B", toneB & 16'hFFF8, 16'h0000);
      if (k <= 120) histA[k-1] = toneA;
      else chk("R4 group A repeat", toneA, histA[(k-1) % 120]);
      if (k <= 105) histB[k-1] = toneB;
      else if (k <= 210) chk("R4 group B repeat", toneB, histB[(k-1) % 105]);
    end
  endtask

  task automatic testDuty();
    int hiA [13];
    int hiB [3];
    doReset();
    foreach (hiA[i]) hiA[i] = 0;
    foreach (hiB[i]) hiB[i] = 0;
    for (int c = 0; c < 420; c++) begin
      tick(1'b1);
      if (c < 120) for (int i = 0; i < 13; i++) hiA[i] += toneA[i];
      if (c < 105) for (int i = 0; i < 3; i++) hiB[i] += toneB[i];
    end
    for (int i = 0; i < 13; i++)
      chk("R2 high count A", 16'(hiA[i]), 16'((120 / ratA[i]) * (ratA[i] / 2)));
    for (int i = 0; i < 3; i++)
      chk("R2 odd high count B", 16'(hiB[i]), 16'((105 / ratB[i]) * (ratB[i] / 2)));
  endtask

  task automatic testHold();
    logic [15:0] a0;
    logic [15:0] b0;
    repeat (7) tick(1'b1);
    a0 = toneA;
    b0 = toneB;
    for (int c = 0; c < 6; c++) begin
      tick(1'b0);
      chk("R6 hold A", toneA, a0);
      chk("R6 hold B", toneB, b0);
    end
    tick(1'b1);
    chk("R6 resume A", toneA, expA(k));
    chk("R6 resume B", toneB, expB(k));
  endtask

  task automatic testMixed();
    for (int c = 0; c < 150; c++) begin
      tick(((c % 3) != 1));
      chk("R7 mixed enable A", toneA, expA(k));
      chk("R7 mixed enable B", toneB, expB(k));
    end
  endtask

  task automatic testMidReset();
    repeat (11) tick(1'b1);
    doReset();
    tick(1'b1);
    chk("R1 R7 restart A", toneA, 16'h1FFF);
    chk("R1 R7 restart B", toneB, 16'h0007);
  endtask

  initial begin
    @(negedge clk);
    doReset();
    testFirstWord();
    testWrap();
    testDuty();
    testHold();
    testMixed();
    testMidReset();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule